// File: doc/BRIEF.md
# Single-Move Transport-Triggered Processor Core

This core has one instruction: move a byte from a source to a destination. Each clock it fetches a 13-bit move word from an external program memory at the current program counter and executes it in the same cycle. The source is either one of the core's internal ports or an 8-bit constant carried in the word. That byte goes onto a single shared 8-bit bus, and the write strobe of the chosen destination fires. No opcode is decoded. Every side effect comes from the destination or source address a move names: ALU work, stack traffic, jumps and data-memory access.

The ports reachable on the bus are two general-purpose registers, an ALU, a LIFO stack, the two program-counter bytes and a data-memory window. The ALU has a first-operand port, a second-operand port that triggers the operation, a function select, and result, carry and zero sources. The stack has a push destination and a pop source. The data-memory window has a 16-bit address pointer, a write destination and a read source. Software builds a call by pushing the return address, which it reads from the next-PC sources. It returns by moving popped bytes into the program-counter bytes.

Top module: `move_core`

## Requirements
- R1: While rst_ni is low, imem_addr_o is 0 and stk_err_o is 0. The first fetch after reset release is from address 0, with an empty stack.
- R2: Move word layout: bit 12 is the constant flag, bits 11:8 the destination, bits 7:0 the source field. With the flag set, the source field itself goes on the bus. Destination 11 writes the bus to data memory (dmem_we_o high, dmem_wdata_o equal to the bus).
- R3: Destinations 1 and 2 load general registers A and B. Sources 0 and 1 read them.
- R4: Destinations 0, 14 and 15 change no state. A source code with no assigned port (9 and up) reads as 0.
- R5: One move executes per clock. Unless a jump is taken, the fetch address rises by one each cycle.
- R6: Destination 7 only stages the upper PC byte; it causes no jump. Destination 8 loads the PC with {staged byte, bus}, and the next fetch comes from that address.
- R7: Destination 12 jumps like 8 only if the ALU zero flag is set. Destination 13 jumps only if the ALU carry flag is set. Otherwise the PC steps by one.
- R8: Destination 6 pushes the bus onto the stack. Source 5 returns the top entry and removes it, in last-in first-out order.
- R9: A pop of an empty stack reads 0 and leaves the stack empty. A push to a full stack is dropped. Either event sets stk_err_o, which stays set until reset.
- R10: Destination 3 loads ALU operand A and destination 5 loads the function (bus bits 2:0). Writing destination 4 computes A op bus. From the next cycle, result, carry and zero (1 when the result is 0) read as sources 2, 3 and 4. Function codes and carry:
  - 0: add, carry out.
  - 1: subtract, carry is the borrow.
  - 2, 3, 4: and, or, xor, carry 0.
  - 5: shift A left, carry is the old bit 7.
  - 6: shift A right, carry is the old bit 0.
  - 7: add with carry in.
- R11: Sources 7 and 8 read the low and high bytes of the current move's address plus one.
- R12: Destinations 9 and 10 load the low and high bytes of dmem_addr_o. Source 6 reads dmem_rdata_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| imem_addr_o | output | 16 | Program fetch address (PC) |
| imem_data_i | input | 13 | Move word at imem_addr_o, same cycle |
| dmem_addr_o | output | 16 | Data memory address pointer |
| dmem_wdata_o | output | 8 | Data memory write byte (the bus) |
| dmem_we_o | output | 1 | Data memory write strobe |
| dmem_rdata_i | input | 8 | Data memory read byte, combinational |
| stk_err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench checks that staging the upper PC byte does not jump. A core that jumped on that write would skip the move placed after it. The same test checks that the jump lands on the full 16-bit target, so a design that loaded only the low byte would fetch from the wrong page.

Conditional jumps are run both taken and not taken, after an ALU result that sets zero and clears carry. Swapped flags would execute the wrong marker moves. The ALU cases cover:
- carry out on add;
- borrow on subtract;
- shift-out bits;
- carry in on add-with-carry.

An off-by-one carry rule shows up as a wrong byte in data memory.

The stack tests push past full and pop past empty. They expect the dropped push to leave the stored entries intact, the empty pop to read 0, and the error flag to stay set until reset.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int DW     = 8;
  localparam int DST_W  = 4;
  localparam int IW     = 1 + DST_W + DW;
  localparam int AW     = 2 * DW;
  localparam int NUM_GPR = 2;

  typedef enum logic [DST_W-1:0] {
    D_NOP     = 4'd0,
    D_GPR0    = 4'd1,
    D_GPR1    = 4'd2,
    D_ALU_A   = 4'd3,
    D_ALU_B   = 4'd4,
    D_ALU_FN  = 4'd5,
    D_PUSH    = 4'd6,
    D_PC_HI   = 4'd7,
    D_PC_LO   = 4'd8,
    D_MADR_LO = 4'd9,
    D_MADR_HI = 4'd10,
    D_MEM_WR  = 4'd11,
    D_JMP_Z   = 4'd12,
    D_JMP_C   = 4'd13
  } dst_e;

  localparam logic [DW-1:0] S_GPR0   = 8'd0;
  localparam logic [DW-1:0] S_ALU_R  = 8'd2;
  localparam logic [DW-1:0] S_ALU_C  = 8'd3;
  localparam logic [DW-1:0] S_ALU_Z  = 8'd4;
  localparam logic [DW-1:0] S_POP    = 8'd5;
  localparam logic [DW-1:0] S_MEM    = 8'd6;
  localparam logic [DW-1:0] S_RET_LO = 8'd7;
  localparam logic [DW-1:0] S_RET_HI = 8'd8;

  typedef enum logic [2:0] {
    F_ADD = 3'd0,
    F_SUB = 3'd1,
    F_AND = 3'd2,
    F_OR  = 3'd3,
    F_XOR = 3'd4,
    F_SHL = 3'd5,
    F_SHR = 3'd6,
    F_ADC = 3'd7
  } alu_fn_e;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          opa_we_i,
  input  logic          fn_we_i,
  input  logic          trig_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] res_o,
  output logic          carry_o,
  output logic          zero_o
);
  logic [DW-1:0] opa_q;
  alu_fn_e       fn_q;
  logic [DW:0]   calc;

  always_comb begin
    calc = '0;
    unique case (fn_q)
      F_ADD: calc = {1'b0, opa_q} + {1'b0, bus_i};
      F_SUB: calc = {1'b0, opa_q} - {1'b0, bus_i};
      F_AND: calc = {1'b0, opa_q & bus_i};
      F_OR:  calc = {1'b0, opa_q | bus_i};
      F_XOR: calc = {1'b0, opa_q ^ bus_i};
      F_SHL: calc = {opa_q[DW-1], opa_q[DW-2:0], 1'b0};
      F_SHR: calc = {opa_q[0], 1'b0, opa_q[DW-1:1]};
      F_ADC: calc = {1'b0, opa_q} + {1'b0, bus_i} + {{DW{1'b0}}, carry_o};
      default: calc = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opa_q   <= '0;
      fn_q    <= F_ADD;
      res_o   <= '0;
      carry_o <= 1'b0;
      zero_o  <= 1'b0;
    end else begin
      if (opa_we_i) opa_q <= bus_i;
      if (fn_we_i)  fn_q  <= alu_fn_e'(bus_i[2:0]);
      if (trig_i) begin
        res_o   <= calc[DW-1:0];
        carry_o <= calc[DW];
        zero_o  <= (calc[DW-1:0] == '0);
      end
    end
  end
endmodule

// File: rtl/mc_stack.sv
module mc_stack #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] top_o,
  output logic          err_o
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] sp_q, sp_mid, top_idx;
  logic          empty, pop_ok, push_ok;

  assign empty   = (sp_q == '0);
  assign pop_ok  = pop_i && !empty;
  assign top_idx = sp_q - PW'(1);
  assign sp_mid  = pop_ok ? top_idx : sp_q;
  assign push_ok = push_i && (sp_mid != FULL);

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (!empty && top_idx == PW'(i)) top_o = mem_q[i];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (push_ok && sp_mid == PW'(g)) mem_q[g] <= din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      err_o <= 1'b0;
    end else begin
      sp_q <= sp_mid + PW'(push_ok);
      if ((pop_i && empty) || (push_i && sp_mid == FULL)) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/mc_pc.sv
module mc_pc #(
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hi_we_i,
  input  logic            jump_i,
  input  logic [DW-1:0]   bus_i,
  output logic [2*DW-1:0] pc_o,
  output logic [2*DW-1:0] pc_inc_o
);
  logic [DW-1:0] stage_q;

  assign pc_inc_o = pc_o + (2*DW)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o    <= '0;
      stage_q <= '0;
    end else begin
      if (hi_we_i) stage_q <= bus_i;
      pc_o <= jump_i ? {stage_q, bus_i} : pc_inc_o;
    end
  end
endmodule

// File: rtl/move_core.sv
module move_core
  import mc_pkg::*;
#(
  parameter int STK_DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] imem_addr_o,
  input  logic [IW-1:0] imem_data_i,
  output logic [AW-1:0] dmem_addr_o,
  output logic [DW-1:0] dmem_wdata_o,
  output logic          dmem_we_o,
  input  logic [DW-1:0] dmem_rdata_i,
  output logic          stk_err_o
);
  logic             imm;
  logic [DST_W-1:0] dst;
  logic [DW-1:0]    src;
  logic [DW-1:0]    bus;
  logic [DW-1:0]    gpr_q [NUM_GPR];
  logic [DW-1:0]    madr_lo_q, madr_hi_q;
  logic [DW-1:0]    alu_res, stk_top;
  logic             alu_c, alu_z, pop, jump;
  logic [AW-1:0]    pc, pc_inc;

  assign imm = imem_data_i[IW-1];
  assign dst = imem_data_i[IW-2 -: DST_W];
  assign src = imem_data_i[DW-1:0];
  assign pop = !imm && (src == S_POP);

  // source driver select
  always_comb begin
    bus = '0;
    if (imm) bus = src;
    else begin
      for (int g = 0; g < NUM_GPR; g++)
        if (src == S_GPR0 + DW'(g)) bus = gpr_q[g];
      unique case (src)
        S_ALU_R:  bus = alu_res;
        S_ALU_C:  bus = {{(DW-1){1'b0}}, alu_c};
        S_ALU_Z:  bus = {{(DW-1){1'b0}}, alu_z};
        S_POP:    bus = stk_top;
        S_MEM:    bus = dmem_rdata_i;
        S_RET_LO: bus = pc_inc[DW-1:0];
        S_RET_HI: bus = pc_inc[AW-1:DW];
        default: ;
      endcase
    end
  end

  assign jump = (dst == D_PC_LO) ||
                (dst == D_JMP_Z && alu_z) ||
                (dst == D_JMP_C && alu_c);

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) gpr_q[g] <= '0;
      else if (dst == D_GPR0 + DST_W'(g)) gpr_q[g] <= bus;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      madr_lo_q <= '0;
      madr_hi_q <= '0;
    end else begin
      if (dst == D_MADR_LO) madr_lo_q <= bus;
      if (dst == D_MADR_HI) madr_hi_q <= bus;
    end
  end

  mc_alu u_alu (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opa_we_i (dst == D_ALU_A),
    .fn_we_i  (dst == D_ALU_FN),
    .trig_i   (dst == D_ALU_B),
    .bus_i    (bus),
    .res_o    (alu_res),
    .carry_o  (alu_c),
    .zero_o   (alu_z)
  );

  mc_stack #(.DW(DW), .DEPTH(STK_DEPTH)) u_stk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (dst == D_PUSH),
    .pop_i  (pop),
    .din_i  (bus),
    .top_o  (stk_top),
    .err_o  (stk_err_o)
  );

  mc_pc #(.DW(DW)) u_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hi_we_i  (dst == D_PC_HI),
    .jump_i   (jump),
    .bus_i    (bus),
    .pc_o     (pc),
    .pc_inc_o (pc_inc)
  );

  assign imem_addr_o  = pc;
  assign dmem_addr_o  = {madr_hi_q, madr_lo_q};
  assign dmem_wdata_o = bus;
  assign dmem_we_o    = (dst == D_MEM_WR);
endmodule

// File: rtl/mc_checker.sv
module mc_checker
  import mc_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] imem_addr_o,
  input logic [IW-1:0] imem_data_i,
  input logic [DW-1:0] dmem_wdata_o,
  input logic          dmem_we_o,
  input logic          stk_err_o
);
  logic [DST_W-1:0] d;
  logic             k;
  assign d = imem_data_i[IW-2 -: DST_W];
  assign k = imem_data_i[IW-1];

  a_r5_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d != 4'd8 && d != 4'd12 && d != 4'd13) |=> imem_addr_o == $past(imem_addr_o) + 16'd1);

  a_r6_jump_low_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k && d == 4'd8) |=> imem_addr_o[DW-1:0] == $past(imem_data_i[DW-1:0]));

  a_r2_imm_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k && d == 4'd11) |-> (dmem_we_o && dmem_wdata_o == imem_data_i[DW-1:0]));

  a_r4_nop_no_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d == 4'd0 || d == 4'd14 || d == 4'd15) |-> !dmem_we_o);

  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_err_o |=> stk_err_o);

  a_r1_reset_pc: assert property (@(posedge clk_i)
    !rst_ni |-> (imem_addr_o == '0 && !stk_err_o));
endmodule

bind move_core mc_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .imem_addr_o  (imem_addr_o),
  .imem_data_i  (imem_data_i),
  .dmem_wdata_o (dmem_wdata_o),
  .dmem_we_o    (dmem_we_o),
  .stk_err_o    (stk_err_o)
);

// File: tb/move_core_tb.sv
module move_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] imem_addr, dmem_addr;
  logic [12:0] imem_data;
  logic [7:0]  dmem_wdata, dmem_rdata;
  logic        dmem_we, stk_err;

  logic [12:0] prog [0:1023];
  int          pp;
  logic [7:0]  log_d [0:63];
  logic [15:0] log_a [0:63];
  logic [15:0] trace [0:63];
  int          log_n, cyc;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  assign imem_data  = prog[imem_addr[9:0]];
  assign dmem_rdata = dmem_addr[7:0] ^ 8'h5A;

  move_core u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .dmem_addr_o(dmem_addr), .dmem_wdata_o(dmem_wdata),
    .dmem_we_o(dmem_we), .dmem_rdata_i(dmem_rdata),
    .stk_err_o(stk_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (cyc < 64) trace[cyc] = imem_addr;
      cyc = cyc + 1;
      if (dmem_we && log_n < 64) begin
        log_d[log_n] = dmem_wdata;
        log_a[log_n] = dmem_addr;
        log_n = log_n + 1;
      end
    end
  end

  task automatic chk(string req, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 1024; i++) prog[i] = 13'h0;
    pp = 0;
  endtask

  task automatic put(bit imm, int dst, int src);
    prog[pp] = {imm, dst[3:0], src[7:0]};
    pp++;
  endtask

  task automatic halt();
    int t;
    t = pp + 1;
    put(1, 7, (t >> 8) & 8'hFF);
    put(1, 8, t & 8'hFF);
  endtask

  task automatic run(int n);
    rst_n = 1'b0;
    log_n = 0;
    cyc = 0;
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    clear_prog();
    put(0, 5, 5);  // pop when empty would set the error flag
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 pc in reset", imem_addr, 0);
    chk("R1 err in reset", stk_err, 0);
    run(2);
    chk("R1 first fetch", trace[0], 0);
  endtask

  task automatic t_imm();
    clear_prog();
    put(1, 11, 8'hA5);
    put(1, 11, 8'h5A);
    halt();
    run(10);
    chk("R2 imm store 0", log_d[0], 8'hA5);
    chk("R2 imm store 1", log_d[1], 8'h5A);
    chk("R5 trace 1", trace[1], 1);
    chk("R5 trace 2", trace[2], 2);
  endtask

  task automatic t_regs();
    clear_prog();
    put(1, 1, 8'h3C);
    put(1, 2, 8'hC3);
    put(0, 11, 0);
    put(0, 11, 1);
    put(0, 1, 1);
    put(0, 11, 0);
    halt();
    run(15);
    chk("R3 reg A", log_d[0], 8'h3C);
    chk("R3 reg B", log_d[1], 8'hC3);
    chk("R3 B to A", log_d[2], 8'hC3);
  endtask

  task automatic t_nop();
    clear_prog();
    put(1, 1, 8'h11);
    put(1, 0, 8'h99);
    put(0, 0, 5);     // nop pop of empty stack: source read, no write
    put(1, 14, 8'h77);
    put(1, 15, 8'h55);
    put(0, 11, 0);
    put(0, 11, 200);
    halt();
    run(15);
    chk("R4 nop dst keeps A", log_d[0], 8'h11);
    chk("R4 unused src is 0", log_d[1], 0);
    chk("R4 store count", log_n, 2);
  endtask

  task automatic t_jump();
    clear_prog();
    put(1, 7, 8'h01);
    put(1, 11, 8'hE1);
    put(1, 8, 8'h10);
    pp = 16'h110;
    put(1, 11, 8'h42);
    halt();
    run(12);
    chk("R6 stage no jump", log_d[0], 8'hE1);
    chk("R6 jump target", trace[3], 16'h0110);
    chk("R6 after jump", log_d[1], 8'h42);
  endtask

  task automatic t_cond();
    clear_prog();
    put(1, 5, 1);        // sub
    put(1, 3, 5);
    put(1, 4, 5);        // zero=1 carry=0
    put(1, 7, 0);
    put(1, 12, 8'h20);   // taken
    put(1, 11, 8'hBB);
    pp = 8'h20;
    put(1, 11, 8'hAA);
    put(1, 13, 8'h40);   // not taken
    put(1, 11, 8'hCC);
    halt();
    pp = 8'h40;
    put(1, 11, 8'hDD);
    halt();
    run(20);
    chk("R7 zero jump taken", log_d[0], 8'hAA);
    chk("R7 carry jump not taken", log_d[1], 8'hCC);
    chk("R7 store count", log_n, 2);
  endtask

  task automatic alu_op(int fn, int a, int b);
    put(1, 5, fn);
    put(1, 3, a);
    put(1, 4, b);
    put(0, 11, 2);
    put(0, 11, 3);
  endtask

  task automatic t_alu();
    clear_prog();
    alu_op(0, 8'hF0, 8'h20);
    put(0, 11, 4);
    alu_op(1, 8'h10, 8'h20);
    alu_op(2, 8'hF0, 8'h3C);
    alu_op(4, 8'hAA, 8'hAA);
    put(0, 11, 4);
    alu_op(5, 8'h81, 0);
    alu_op(6, 8'h81, 0);
    alu_op(7, 8'h01, 8'h01);
    halt();
    run(50);
    chk("R10 add res", log_d[0], 8'h10);
    chk("R10 add carry", log_d[1], 1);
    chk("R10 add zero", log_d[2], 0);
    chk("R10 sub res", log_d[3], 8'hF0);
    chk("R10 sub borrow", log_d[4], 1);
    chk("R10 and res", log_d[5], 8'h30);
    chk("R10 xor res", log_d[7], 0);
    chk("R10 xor zero", log_d[9], 1);
    chk("R10 shl res", log_d[10], 8'h02);
    chk("R10 shl carry", log_d[11], 1);
    chk("R10 shr res", log_d[12], 8'h40);
    chk("R10 shr carry", log_d[13], 1);
    chk("R10 adc res", log_d[14], 8'h03);
    chk("R10 adc carry", log_d[15], 0);
  endtask

  task automatic t_stack();
    clear_prog();
    put(1, 6, 8'h11);
    put(1, 6, 8'h22);
    put(1, 6, 8'h33);
    put(0, 11, 5);
    put(0, 11, 5);
    put(0, 11, 5);
    halt();
    run(15);
    chk("R8 pop 0", log_d[0], 8'h33);
    chk("R8 pop 1", log_d[1], 8'h22);
    chk("R8 pop 2", log_d[2], 8'h11);
    chk("R8 no err", stk_err, 0);
  endtask

  task automatic t_stack_err();
    clear_prog();
    put(0, 11, 5);
    put(1, 6, 8'h5A);
    put(0, 11, 5);
    halt();
    run(10);
    chk("R9 underflow reads 0", log_d[0], 0);
    chk("R9 empty after underflow", log_d[1], 8'h5A);
    chk("R9 err sticky", stk_err, 1);
    clear_prog();
    for (int i = 1; i <= 9; i++) put(1, 6, i);
    for (int i = 0; i < 9; i++) put(0, 11, 5);
    halt();
    run(30);
    for (int i = 0; i < 8; i++) chk("R9 overflow keeps entries", log_d[i], 8 - i);
    chk("R9 overflow dropped", log_d[8], 0);
    chk("R9 overflow err", stk_err, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears err", stk_err, 0);
  endtask

  task automatic t_ret();
    clear_prog();
    put(1, 7, 8'h01);
    put(1, 8, 8'hF0);
    pp = 16'h1F0;
    put(0, 11, 7);
    put(0, 11, 8);
    halt();
    run(12);
    chk("R11 next pc lo", log_d[0], 8'hF1);
    chk("R11 next pc hi", log_d[1], 8'h01);
  endtask

  task automatic t_mem();
    clear_prog();
    put(1, 9, 8'h34);
    put(1, 10, 8'h12);
    put(1, 11, 8'h77);
    put(0, 1, 6);
    put(0, 11, 0);
    halt();
    run(12);
    chk("R12 store addr", log_a[0], 16'h1234);
    chk("R12 store data", log_d[0], 8'h77);
    chk("R12 read data", log_d[1], 8'h34 ^ 8'h5A);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    log_n = 0;
    cyc = 0;
    clear_prog();
    t_reset();
    t_imm();
    t_regs();
    t_nop();
    t_jump();
    t_cond();
    t_alu();
    t_stack();
    t_stack_err();
    t_ret();
    t_mem();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule